// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block paces a micro-coded 8-bit controller. It takes the oscillator clock and breaks it into machine cycles. Each machine cycle has six states, and each state has two phases, so one machine cycle lasts twelve oscillator periods. Within each machine cycle the block gives the current state index and phase. It also gives two address-latch pulses for an external multiplexed address/data bus, two code-fetch strobes (so a two-byte instruction can complete in one machine cycle), and a strobe that marks the end of each machine cycle.

The instruction decoder supplies the number of machine cycles the current instruction needs. The sequencer samples that count only at an instruction boundary and holds the instruction open for that many machine cycles. At the last period of the instruction it raises a one-period done strobe. A count of zero runs as a single machine cycle. All outputs are registered and line up with the state and phase outputs in the same clock period.

Top module: `mcs_timing_top`

## Requirements
- R1: A synchronous active-high reset puts the block in state 0, phase 0. While reset is high, and in the first period after it, `addr_latch`, `fetch_a`, `fetch_b`, `mcyc_end` and `instr_done` are all low.
- R2: `phase` alternates every oscillator period. `state_idx` advances by one after each phase-1 period and goes from 5 back to 0, so a machine cycle lasts 12 periods. Position t = 2*state_idx + phase.
- R3: `addr_latch` is high exactly at t = 1, 2, 7 and 8 of every machine cycle. These are (state 0, phase 1), (state 1, phase 0), (state 3, phase 1) and (state 4, phase 0), which gives two pulses per machine cycle, each two periods long.
- R4: `fetch_a` is high only at t = 1 (end of state 0). `fetch_b` is high only at t = 7 (end of state 3).
- R5: `mcyc_end` is high only at t = 11 (state 5, phase 1).
- R6: `instr_done` is high for one period, at t = 11 of the N-th machine cycle of an instruction. N is the value of `instr_cycles` sampled at the clock edge that starts the instruction: either the last reset edge, or the edge that leaves t = 11 of the previous instruction's final machine cycle.
- R7: An `instr_cycles` value of 0 runs as N = 1.
- R8: Changes on `instr_cycles` at any other clock edge have no effect on when `instr_done` occurs.
- R9: The largest count, 2^CYC_W - 1 (7 by default), runs for that many machine cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_cycles | input | CYC_W | Machine cycles needed by the next instruction |
| state_idx | output | ST_W | Current state, 0 to 5 |
| phase | output | 1 | Current phase within the state |
| addr_latch | output | 1 | Address latch enable for the external bus |
| fetch_a | output | 1 | First code-fetch strobe |
| fetch_b | output | 1 | Second code-fetch strobe |
| mcyc_end | output | 1 | Last period of each machine cycle |
| instr_done | output | 1 | Last period of the instruction |

## Verification
The bench runs a sequence of instructions with counts of 2, 1, 0, 3, 7, 1 and 5. While each instruction runs, it drives changing junk values on the count input. Any of the following faults would move or remove the done strobe:
- a design that reloads the count mid-instruction,
- a design that takes zero literally (wrapping to 8 cycles or never finishing),
- a design that loses the top count value.

The bench compares the latch and fetch timing at every period, so shifting a pulse by one phase (a common off-by-one between the registered and next-state decode) is caught. It also resets the block in the middle of a machine cycle to confirm that a stale count or a stale strobe does not survive the reset.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  // Phase inside one state: low half, then high half.
  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } mcs_phase_e;

  // Strobe bundle produced per oscillator period.
  typedef struct packed {
    logic latch;
    logic fetch_a;
    logic fetch_b;
    logic cyc_end;
  } mcs_strobes_t;

endpackage

// File: rtl/mcs_frame_ctr.sv
module mcs_frame_ctr #(
  parameter int N_STATES = 6,
  localparam int ST_W = $clog2(N_STATES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ST_W-1:0] state_q,
  output logic            phase_q,
  output logic [ST_W-1:0] nxt_state,
  output logic            nxt_phase,
  output logic            at_last
);
  import mcs_pkg::*;

  localparam logic [ST_W-1:0] LAST_ST = ST_W'(N_STATES - 1);

  assign at_last = (state_q == LAST_ST) && (phase_q == PH_HI);

  always_comb begin
    if (rst) begin
      nxt_state = '0;
      nxt_phase = PH_LO;
    end else if (phase_q == PH_LO) begin
      nxt_state = state_q;
      nxt_phase = PH_HI;
    end else begin
      nxt_phase = PH_LO;
      nxt_state = (state_q == LAST_ST) ? '0 : state_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    state_q <= nxt_state;
    phase_q <= nxt_phase;
  end

  // R1: reset lands in state 0, phase 0
  a_r1_reset_origin: assert property (@(posedge clk)
    rst |=> (state_q == '0 && phase_q == PH_LO));

  // R2: phase alternates every period
  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase_q != $past(phase_q)));

  // R2: wrap from the last state back to state 0
  a_r2_state_wrap: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (state_q == '0));

endmodule

// File: rtl/mcs_strobe_dec.sv
module mcs_strobe_dec #(
  parameter int N_STATES = 6,
  localparam int ST_W   = $clog2(N_STATES),
  localparam int SLOT_B = N_STATES / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] nxt_state,
  input  logic            nxt_phase,
  output logic            latch_q,
  output logic            fetch_a_q,
  output logic            fetch_b_q,
  output logic            cyc_end_q
);
  import mcs_pkg::*;

  localparam logic [ST_W-1:0] S_A0 = '0;
  localparam logic [ST_W-1:0] S_A1 = ST_W'(1);
  localparam logic [ST_W-1:0] S_B0 = ST_W'(SLOT_B);
  localparam logic [ST_W-1:0] S_B1 = ST_W'(SLOT_B + 1);
  localparam logic [ST_W-1:0] S_LS = ST_W'(N_STATES - 1);

  mcs_strobes_t nxt;

  // Decode the coming period so the registered strobes align with state/phase.
  always_comb begin
    nxt.latch   = ((nxt_phase == PH_HI) && (nxt_state == S_A0 || nxt_state == S_B0)) ||
                  ((nxt_phase == PH_LO) && (nxt_state == S_A1 || nxt_state == S_B1));
    nxt.fetch_a = (nxt_phase == PH_HI) && (nxt_state == S_A0);
    nxt.fetch_b = (nxt_phase == PH_HI) && (nxt_state == S_B0);
    nxt.cyc_end = (nxt_phase == PH_HI) && (nxt_state == S_LS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= 1'b0;
      fetch_a_q <= 1'b0;
      fetch_b_q <= 1'b0;
      cyc_end_q <= 1'b0;
    end else begin
      latch_q   <= nxt.latch;
      fetch_a_q <= nxt.fetch_a;
      fetch_b_q <= nxt.fetch_b;
      cyc_end_q <= nxt.cyc_end;
    end
  end

  // R3: each latch pulse lasts two periods (rises, then holds once)
  a_r3_latch_width: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |=> latch_q);

  // R4: a fetch strobe is a single-period pulse
  a_r4_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
    (fetch_a_q || fetch_b_q) |=> !(fetch_a_q || fetch_b_q));

endmodule

// File: rtl/mcs_cycle_track.sv
module mcs_cycle_track #(
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_last,
  input  logic             nxt_last,
  input  logic [CYC_W-1:0] instr_cycles,
  output logic             done_q
);
  logic [CYC_W-1:0] left_q;
  logic [CYC_W-1:0] load_val;

  // Zero behaves as one machine cycle.
  assign load_val = (instr_cycles == '0) ? '0 : instr_cycles - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= load_val;
    end else if (at_last) begin
      left_q <= (left_q == '0) ? load_val : left_q - 1'b1;
    end
  end

  // left_q does not move between the current period and a coming last period.
  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= nxt_last && (left_q == '0);
  end

  // R8: count is held between machine-cycle boundaries
  a_r8_count_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(at_last)) |-> (left_q == $past(left_q)));

  // R6: done is a single-period pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/mcs_timing_top.sv
module mcs_timing_top #(
  parameter int N_STATES = 6,
  parameter int CYC_W    = 3,
  localparam int ST_W    = $clog2(N_STATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] instr_cycles,
  output logic [ST_W-1:0]  state_idx,
  output logic             phase,
  output logic             addr_latch,
  output logic             fetch_a,
  output logic             fetch_b,
  output logic             mcyc_end,
  output logic             instr_done
);
  logic [ST_W-1:0] nxt_state;
  logic            nxt_phase;
  logic            at_last;
  logic            nxt_last;

  assign nxt_last = (nxt_state == ST_W'(N_STATES - 1)) && nxt_phase;

  mcs_frame_ctr #(.N_STATES(N_STATES)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_idx),
    .phase_q   (phase),
    .nxt_state (nxt_state),
    .nxt_phase (nxt_phase),
    .at_last   (at_last)
  );

  mcs_strobe_dec #(.N_STATES(N_STATES)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .nxt_phase (nxt_phase),
    .latch_q   (addr_latch),
    .fetch_a_q (fetch_a),
    .fetch_b_q (fetch_b),
    .cyc_end_q (mcyc_end)
  );

  mcs_cycle_track #(.CYC_W(CYC_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .at_last      (at_last),
    .nxt_last     (nxt_last),
    .instr_cycles (instr_cycles),
    .done_q       (instr_done)
  );

  // R4: fetch strobes fall inside a latch pulse
  a_r4_fetch_in_latch: assert property (@(posedge clk) disable iff (rst)
    (fetch_a || fetch_b) |-> addr_latch);

  // R3: latch never high in the idle states between the two slots
  a_r3_latch_slots: assert property (@(posedge clk) disable iff (rst)
    addr_latch |-> (state_idx != ST_W'(2) && state_idx != ST_W'(N_STATES - 1)));

  // R5: at most one of the period strobes at a time
  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_a, fetch_b, mcyc_end}));

  // R6: done only at the last period of a machine cycle
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (mcyc_end && phase && state_idx == ST_W'(N_STATES - 1)));

endmodule

// File: tb/mcs_timing_top_tb.sv
module mcs_timing_top_tb;
  localparam int NV = 7;
  localparam logic [2:0] VEC_CNT [NV] = '{3'd2, 3'd1, 3'd0, 3'd3, 3'd7, 3'd1, 3'd5};
  localparam int         VEC_LEN [NV] = '{2, 1, 1, 3, 7, 1, 5};

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] instr_cycles;
  logic [2:0] state_idx;
  logic       phase, addr_latch, fetch_a, fetch_b, mcyc_end, instr_done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  mcs_timing_top u_dut (
    .clk(clk), .rst(rst), .instr_cycles(instr_cycles),
    .state_idx(state_idx), .phase(phase), .addr_latch(addr_latch),
    .fetch_a(fetch_a), .fetch_b(fetch_b), .mcyc_end(mcyc_end),
    .instr_done(instr_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against position t of a machine cycle.
  task automatic chk_period(input int t, input int done_exp, input string done_req);
    chk("R2 state/phase", {state_idx, phase}, t);
    chk("R3 addr_latch", addr_latch, (t == 1 || t == 2 || t == 7 || t == 8));
    chk("R4 fetch", {fetch_a, fetch_b}, {t == 1, t == 7});
    chk("R5 mcyc_end", mcyc_end, t == 11);
    chk(done_req, instr_done, done_exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    instr_cycles = VEC_CNT[0];
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 state/phase", {state_idx, phase}, 0);
    chk("R1 strobes", {addr_latch, fetch_a, fetch_b, mcyc_end, instr_done}, 0);
    rst = 1'b0;

    // Table walk: each instruction with junk on the count input mid-instruction.
    for (int k = 0; k < NV; k++) begin
      for (int c = 0; c < VEC_LEN[k]; c++) begin
        for (int t = 0; t < 12; t++) begin
          automatic bit last = (t == 11) && (c == VEC_LEN[k] - 1);
          automatic string dreq = !last ? "R8 done ignored" :
                                  (VEC_CNT[k] == 3'd0) ? "R7 done zero" :
                                  (VEC_CNT[k] == 3'd7) ? "R9 done max" : "R6 done";
          chk_period(t, last, dreq);
          if (last) instr_cycles = (k + 1 < NV) ? VEC_CNT[k + 1] : 3'd1;
          else      instr_cycles = 3'((k * 5 + c * 3 + t) % 8);
          @(posedge clk); @(negedge clk);
        end
      end
    end

    // Directed: reset in the middle of a machine cycle, new count 3.
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
    end
    rst = 1'b1;
    instr_cycles = 3'd3;
    @(posedge clk); @(negedge clk);
    chk("R1 mid reset state/phase", {state_idx, phase}, 0);
    chk("R1 mid reset strobes", {addr_latch, fetch_a, fetch_b, mcyc_end, instr_done}, 0);
    rst = 1'b0;
    instr_cycles = 3'd1;
    for (int p = 0; p < 36; p++) begin
      chk_period(p % 12, p == 35, p == 35 ? "R6 done after reset" : "R8 done ignored");
      @(posedge clk); @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule